// File: doc/BRIEF.md
# Sub-Cube Address Translation Table

This block turns the absolute address of a voxel in a volume into an address inside one of several cache banks. The volume is cut into cubic sub-cubes of edge n = 2^OFS_W voxels. A voxel's x, y and z coordinates each split into two parts. The upper part of each axis, taken together, names the sub-cube. The lower part of each axis, taken together, is the voxel's position inside that sub-cube. A table with one entry per sub-cube gives the cache bank that holds the sub-cube and the slot where the sub-cube starts inside that bank. The in-bank address is that slot joined with the position inside the sub-cube.

The loader writes an entry each time it places a new sub-cube into a cache, or clears an entry when the sub-cube leaves. The renderer issues lookups. Each lookup returns, one cycle later, either a hit with a bank select and an in-bank address, or a miss. All eight interleaved memory units can share one table, because a sub-cube's index is the same in every unit.

Top module: `subcube_xlat`

## Requirements
- R1: After reset every table entry is invalid, and `resultValid` and `resultMiss` are 0 until the first lookup.
- R2: `resultValid` is 1 exactly in the cycle after a cycle with `lookupValid` = 1, and 0 in every other cycle.
- R3: The sub-cube index is {z[AXIS_W-1:OFS_W], y[AXIS_W-1:OFS_W], x[AXIS_W-1:OFS_W]}, with z in the most significant part. On a hit, `resultAddr` is {slot, z[OFS_W-1:0], y[OFS_W-1:0], x[OFS_W-1:0]}, with the slot in the most significant bits.
- R4: A lookup of an entry that was last written with `updateSet` = 1 reports a hit (`resultMiss` = 0), and returns the bank and slot given by that write.
- R5: A lookup of an invalid entry reports `resultMiss` = 1, with `resultBank` = 0 and `resultAddr` = 0.
- R6: A write with `updateSet` = 0 makes the entry invalid, so later lookups of it miss.
- R7: When a legal write and a lookup name the same entry in the same cycle, the lookup returns the write's data: its bank, its slot and its valid bit.
- R8: A write whose `updateBank` is NUM_BANKS or greater is ignored. The entry keeps its old contents, the write is not forwarded to a lookup in the same cycle, and `resultBank` never shows an illegal bank.
- R9: A later write to an entry replaces the earlier mapping of that entry.
- R10: A write changes only the entry it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | Start a lookup this cycle |
| lookupX | input | AXIS_W | Voxel x coordinate |
| lookupY | input | AXIS_W | Voxel y coordinate |
| lookupZ | input | AXIS_W | Voxel z coordinate |
| updateEn | input | 1 | Write a table entry this cycle |
| updateIdx | input | 3*(AXIS_W-OFS_W) | Sub-cube index to write, laid out {z,y,x} |
| updateBank | input | BANK_W | Cache bank that holds the sub-cube |
| updateSlot | input | SLOT_W | Base slot of the sub-cube in that bank |
| updateSet | input | 1 | 1 marks the entry valid, 0 clears it |
| resultValid | output | 1 | A lookup result is present |
| resultMiss | output | 1 | The looked-up sub-cube is not cached |
| resultBank | output | BANK_W | Selected cache bank (0 on a miss) |
| resultAddr | output | SLOT_W+3*OFS_W | Address inside the bank (0 on a miss) |

## Verification
Every lookup result is due exactly one rising edge after the cycle in which the lookup is driven. A write also takes effect for lookups at that same edge, whether through the table or through the same-cycle forward path. The bench drives on falling edges and records each expected result together with the cycle number at which it is due. A monitor then samples the outputs on the next falling edge. It flags a result that arrives at any other time, a result that fails to arrive on time, and any wrong miss, bank or address.

// File: rtl/subcube_xlat_pkg.sv
package subcube_xlat_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic writeEntry;  // legal table write this cycle
    logic readEntry;   // lookup issued this cycle
    logic forward;     // write and lookup hit the same entry
  } xlat_strobe_t;
endpackage

// File: rtl/subcube_xlat_ctrl.sv
module subcube_xlat_ctrl
  import subcube_xlat_pkg::*;
#(
  parameter int IDX_W     = 9,
  parameter int BANK_W    = 2,
  parameter int NUM_BANKS = 3
) (
  input  logic              lookupValid,
  input  logic [IDX_W-1:0]  lookupIdx,
  input  logic              updateEn,
  input  logic [IDX_W-1:0]  updateIdx,
  input  logic [BANK_W-1:0] updateBank,
  output xlat_strobe_t      strb
);
  logic legalBank;

  always_comb begin
    legalBank       = (int'(updateBank) < NUM_BANKS);
    strb.writeEntry = updateEn && legalBank;
    strb.readEntry  = lookupValid;
    strb.forward    = lookupValid && updateEn && legalBank && (updateIdx == lookupIdx);
  end
endmodule

// File: rtl/subcube_xlat_datapath.sv
module subcube_xlat_datapath
  import subcube_xlat_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int OFS3_W = 3,
  parameter int BANK_W = 2,
  parameter int SLOT_W = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  xlat_strobe_t             strb,
  input  logic [IDX_W-1:0]         lookupIdx,
  input  logic [OFS3_W-1:0]        lookupOfs,
  input  logic [IDX_W-1:0]         updateIdx,
  input  logic [BANK_W-1:0]        updateBank,
  input  logic [SLOT_W-1:0]        updateSlot,
  input  logic                     updateSet,
  output logic                     resultValid,
  output logic                     resultMiss,
  output logic [BANK_W-1:0]        resultBank,
  output logic [SLOT_W+OFS3_W-1:0] resultAddr
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [BANK_W-1:0] bankMem [ENTRIES];
  logic [SLOT_W-1:0] slotMem [ENTRIES];
  logic [ENTRIES-1:0] validBits;

  logic              validQ;
  logic              hitQ;
  logic [BANK_W-1:0] bankQ;
  logic [SLOT_W-1:0] slotQ;
  logic [OFS3_W-1:0] ofsQ;

  // Payload storage carries no reset; only the valid bits do.
  always_ff @(posedge clk) begin
    if (strb.writeEntry) begin
      bankMem[updateIdx] <= updateBank;
      slotMem[updateIdx] <= updateSlot;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validBits <= '0;
    end else if (strb.writeEntry) begin
      validBits[updateIdx] <= updateSet;
    end
  end

  // One-cycle lookup; a coincident write wins over the stored entry.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      hitQ   <= 1'b0;
      bankQ  <= '0;
      slotQ  <= '0;
      ofsQ   <= '0;
    end else begin
      validQ <= strb.readEntry;
      if (strb.readEntry) begin
        ofsQ <= lookupOfs;
        if (strb.forward) begin
          hitQ  <= updateSet;
          bankQ <= updateBank;
          slotQ <= updateSlot;
        end else begin
          hitQ  <= validBits[lookupIdx];
          bankQ <= bankMem[lookupIdx];
          slotQ <= slotMem[lookupIdx];
        end
      end
    end
  end

  always_comb begin
    resultValid = validQ;
    resultMiss  = validQ && !hitQ;
    resultBank  = (validQ && hitQ) ? bankQ : '0;
    resultAddr  = (validQ && hitQ) ? {slotQ, ofsQ} : '0;
  end
endmodule

// File: rtl/subcube_xlat.sv
module subcube_xlat
  import subcube_xlat_pkg::*;
#(
  parameter int AXIS_W    = 4,
  parameter int OFS_W     = 1,
  parameter int NUM_BANKS = 3,
  parameter int SLOT_W    = 6,
  localparam int CUBE_W   = AXIS_W - OFS_W,
  localparam int IDX_W    = 3 * CUBE_W,
  localparam int OFS3_W   = 3 * OFS_W,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = SLOT_W + OFS3_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [AXIS_W-1:0] lookupX,
  input  logic [AXIS_W-1:0] lookupY,
  input  logic [AXIS_W-1:0] lookupZ,
  input  logic              updateEn,
  input  logic [IDX_W-1:0]  updateIdx,
  input  logic [BANK_W-1:0] updateBank,
  input  logic [SLOT_W-1:0] updateSlot,
  input  logic              updateSet,
  output logic              resultValid,
  output logic              resultMiss,
  output logic [BANK_W-1:0] resultBank,
  output logic [ADDR_W-1:0] resultAddr
);
  logic [IDX_W-1:0]  lookupIdx;
  logic [OFS3_W-1:0] lookupOfs;
  xlat_strobe_t      strb;

  assign lookupIdx = {lookupZ[AXIS_W-1:OFS_W], lookupY[AXIS_W-1:OFS_W], lookupX[AXIS_W-1:OFS_W]};
  assign lookupOfs = {lookupZ[OFS_W-1:0], lookupY[OFS_W-1:0], lookupX[OFS_W-1:0]};

  subcube_xlat_ctrl #(
    .IDX_W(IDX_W), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)
  ) u_ctrl (
    .lookupValid(lookupValid),
    .lookupIdx  (lookupIdx),
    .updateEn   (updateEn),
    .updateIdx  (updateIdx),
    .updateBank (updateBank),
    .strb       (strb)
  );

  subcube_xlat_datapath #(
    .IDX_W(IDX_W), .OFS3_W(OFS3_W), .BANK_W(BANK_W), .SLOT_W(SLOT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .lookupIdx  (lookupIdx),
    .lookupOfs  (lookupOfs),
    .updateIdx  (updateIdx),
    .updateBank (updateBank),
    .updateSlot (updateSlot),
    .updateSet  (updateSet),
    .resultValid(resultValid),
    .resultMiss (resultMiss),
    .resultBank (resultBank),
    .resultAddr (resultAddr)
  );
endmodule

// File: rtl/subcube_xlat_chk.sv
module subcube_xlat_chk #(
  parameter int AXIS_W    = 4,
  parameter int OFS_W     = 1,
  parameter int NUM_BANKS = 3,
  parameter int SLOT_W    = 6,
  localparam int CUBE_W   = AXIS_W - OFS_W,
  localparam int IDX_W    = 3 * CUBE_W,
  localparam int OFS3_W   = 3 * OFS_W,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = SLOT_W + OFS3_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              lookupValid,
  input logic [AXIS_W-1:0] lookupX,
  input logic [AXIS_W-1:0] lookupY,
  input logic [AXIS_W-1:0] lookupZ,
  input logic              updateEn,
  input logic [IDX_W-1:0]  updateIdx,
  input logic [BANK_W-1:0] updateBank,
  input logic [SLOT_W-1:0] updateSlot,
  input logic              updateSet,
  input logic              resultValid,
  input logic              resultMiss,
  input logic [BANK_W-1:0] resultBank,
  input logic [ADDR_W-1:0] resultAddr
);
  logic [OFS3_W-1:0] chkOfs;
  logic              sameEntry;

  assign chkOfs    = {lookupZ[OFS_W-1:0], lookupY[OFS_W-1:0], lookupX[OFS_W-1:0]};
  assign sameEntry = updateIdx == {lookupZ[AXIS_W-1:OFS_W], lookupY[AXIS_W-1:OFS_W], lookupX[AXIS_W-1:OFS_W]};

  // R2: a result follows every lookup by one cycle.
  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> resultValid);
  // R2: no result without a lookup.
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !resultValid);
  // R5: a miss carries zero bank and address and only appears with a result.
  assert_miss_zeroed_R5: assert property (@(posedge clk) disable iff (!rstN)
    resultMiss |-> (resultValid && resultBank == '0 && resultAddr == '0));
  // R3: the low address bits are the in-cube offset of the lookup.
  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !resultMiss) ##1 !resultMiss |-> resultAddr[OFS3_W-1:0] == $past(chkOfs));
  // R7: a legal valid write to the looked-up entry is forwarded.
  assert_forward_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && updateEn && updateSet && int'(updateBank) < NUM_BANKS && sameEntry)
    |=> (!resultMiss && resultBank == $past(updateBank)
         && resultAddr[ADDR_W-1:OFS3_W] == $past(updateSlot)));
  // R8: an illegal bank never reaches the output.
  assert_bank_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> int'(resultBank) < NUM_BANKS);
endmodule

bind subcube_xlat subcube_xlat_chk #(
  .AXIS_W(AXIS_W), .OFS_W(OFS_W), .NUM_BANKS(NUM_BANKS), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid),
  .lookupX(lookupX), .lookupY(lookupY), .lookupZ(lookupZ),
  .updateEn(updateEn), .updateIdx(updateIdx), .updateBank(updateBank),
  .updateSlot(updateSlot), .updateSet(updateSet),
  .resultValid(resultValid), .resultMiss(resultMiss),
  .resultBank(resultBank), .resultAddr(resultAddr)
);

// File: tb/tb_subcube_xlat.sv
module tb_subcube_xlat;
  localparam int ENTRIES = 512;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lookupValid = 1'b0;
  logic [3:0] lookupX = '0, lookupY = '0, lookupZ = '0;
  logic       updateEn = 1'b0;
  logic [8:0] updateIdx = '0;
  logic [1:0] updateBank = '0;
  logic [5:0] updateSlot = '0;
  logic       updateSet = 1'b0;
  logic       resultValid, resultMiss;
  logic [1:0] resultBank;
  logic [8:0] resultAddr;

  subcube_xlat dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid),
    .lookupX(lookupX), .lookupY(lookupY), .lookupZ(lookupZ),
    .updateEn(updateEn), .updateIdx(updateIdx), .updateBank(updateBank),
    .updateSlot(updateSlot), .updateSet(updateSet),
    .resultValid(resultValid), .resultMiss(resultMiss),
    .resultBank(resultBank), .resultAddr(resultAddr)
  );

  always #5 clk = ~clk;

  typedef struct {
    int         due;
    bit         miss;
    logic [1:0] bank;
    logic [8:0] addr;
    string      tag;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;
  bit   finished = 1'b0;

  bit         refValid [ENTRIES];
  logic [1:0] refBank  [ENTRIES];
  logic [5:0] refSlot  [ENTRIES];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare outputs one falling edge after the due edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (resultValid) begin
        checks++;
        if (expQ.size() == 0 || expQ[0].due != cyc) begin
          failures++;
          $display("FAIL R2 unexpected result: actual valid=1 expected valid=0 at cycle %0d", cyc);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          if (resultMiss !== e.miss || resultBank !== e.bank || resultAddr !== e.addr) begin
            failures++;
            $display("FAIL %s: actual miss=%0b bank=%0d addr=%h expected miss=%0b bank=%0d addr=%h",
                     e.tag, resultMiss, resultBank, resultAddr, e.miss, e.bank, e.addr);
          end
        end
      end else if (expQ.size() != 0 && expQ[0].due == cyc) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        failures++;
        $display("FAIL R2 missing result (%s): actual valid=0 expected valid=1", e.tag);
      end
    end
  end

  // Driver: one cycle of stimulus, expectation pushed to the scoreboard.
  task automatic doCycle(input bit lk, input logic [3:0] x, input logic [3:0] y, input logic [3:0] z,
                         input bit up, input logic [8:0] uIdx, input logic [1:0] uBank,
                         input logic [5:0] uSlot, input bit uSet, input string tag);
    logic [8:0] idx;
    bit         legal;
    exp_t       e;
    @(negedge clk);
    lookupValid = lk; lookupX = x; lookupY = y; lookupZ = z;
    updateEn = up; updateIdx = uIdx; updateBank = uBank; updateSlot = uSlot; updateSet = uSet;
    idx   = {z[3:1], y[3:1], x[3:1]};
    legal = up && (uBank < 2'd3);
    if (lk) begin
      bit         v;
      logic [1:0] b;
      logic [5:0] s;
      if (legal && uIdx == idx) begin v = uSet; b = uBank; s = uSlot; end
      else begin v = refValid[idx]; b = refBank[idx]; s = refSlot[idx]; end
      e.due  = cyc + 1;
      e.miss = !v;
      e.bank = v ? b : 2'd0;
      e.addr = v ? {s, z[0], y[0], x[0]} : 9'd0;
      e.tag  = tag;
      expQ.push_back(e);
    end
    if (legal) begin
      refValid[uIdx] = uSet; refBank[uIdx] = uBank; refSlot[uIdx] = uSlot;
    end
  endtask

  task automatic doLookup(input logic [3:0] x, input logic [3:0] y, input logic [3:0] z, input string tag);
    doCycle(1'b1, x, y, z, 1'b0, 9'd0, 2'd0, 6'd0, 1'b0, tag);
  endtask

  task automatic doWrite(input logic [8:0] idx, input logic [1:0] b, input logic [5:0] s, input bit set);
    doCycle(1'b0, 4'd0, 4'd0, 4'd0, 1'b1, idx, b, s, set, "write");
  endtask

  task automatic idle();
    doCycle(1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 9'd0, 2'd0, 6'd0, 1'b0, "idle");
  endtask

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin refValid[i] = 0; refBank[i] = '0; refSlot[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (resultValid !== 1'b0 || resultMiss !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset outputs: actual valid=%0b miss=%0b expected 0 0", resultValid, resultMiss);
    end
    // R1/R5: every entry is invalid after reset
    doLookup(4'd0, 4'd0, 4'd0, "R1 first entry miss");
    doLookup(4'd15, 4'd15, 4'd15, "R1 last entry miss");
    doLookup(4'd7, 4'd3, 4'd9, "R5 miss zeroed");
    idle();
    // R4/R3: fill and read back with different offsets
    doWrite({3'd4, 3'd1, 3'd3}, 2'd2, 6'd45, 1'b1);
    doLookup(4'd6, 4'd2, 4'd8, "R3 offset 000");
    doLookup(4'd7, 4'd3, 4'd9, "R3 offset 111");
    doLookup(4'd6, 4'd3, 4'd8, "R4 hit offset 010");
    doWrite(9'd0, 2'd1, 6'd63, 1'b1);
    doLookup(4'd1, 4'd0, 4'd0, "R4 hit entry 0");
    // R10: neighbours untouched
    doLookup(4'd2, 4'd0, 4'd0, "R10 neighbour x");
    doLookup(4'd0, 4'd0, 4'd2, "R10 neighbour z");
    // R9: remap
    doWrite(9'd0, 2'd0, 6'd5, 1'b1);
    doLookup(4'd0, 4'd1, 4'd1, "R9 remap");
    // R6: invalidate
    doWrite({3'd4, 3'd1, 3'd3}, 2'd0, 6'd0, 1'b0);
    doLookup(4'd6, 4'd2, 4'd8, "R6 invalidated");
    // R7: forwarding of set and of clear
    doCycle(1'b1, 4'd10, 4'd12, 4'd14, 1'b1, {3'd7, 3'd6, 3'd5}, 2'd2, 6'd17, 1'b1, "R7 forward set");
    doLookup(4'd11, 4'd12, 4'd14, "R7 stored after forward");
    doCycle(1'b1, 4'd10, 4'd12, 4'd14, 1'b1, {3'd7, 3'd6, 3'd5}, 2'd1, 6'd3, 1'b0, "R7 forward clear");
    doCycle(1'b1, 4'd0, 4'd0, 4'd0, 1'b1, 9'd1, 2'd1, 6'd9, 1'b1, "R7 other entry no forward");
    // R8: illegal bank ignored
    doCycle(1'b1, 4'd0, 4'd0, 4'd0, 1'b1, 9'd0, 2'd3, 6'd40, 1'b1, "R8 no forward");
    doLookup(4'd0, 4'd0, 4'd0, "R8 entry kept");
    doWrite(9'd100, 2'd3, 6'd1, 1'b1);
    doLookup({3'd4, 1'b0}, {3'd4, 1'b1}, {3'd1, 1'b0}, "R8 invalid stays invalid");
    // R2: idle gap then back-to-back
    idle(); idle();
    for (int i = 0; i < 400; i++) begin
      logic [3:0] x, y, z;
      bit         lk, up;
      x = 4'($urandom_range(0, 15)); y = 4'($urandom_range(0, 3)); z = 4'($urandom_range(0, 3));
      lk = ($urandom_range(0, 3) != 0);
      up = ($urandom_range(0, 2) == 0);
      doCycle(lk, x, y, z, up, {3'($urandom_range(0, 1)), 3'($urandom_range(0, 1)), 3'($urandom_range(0, 7))},
              2'($urandom_range(0, 3)), 6'($urandom), bit'($urandom_range(0, 3) != 0), "R4 R2 mixed traffic");
    end
    idle(); idle(); idle();
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R2 pending results: actual=%0d expected=0", expQ.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule